// File: doc/BRIEF.md
# Speaker Output Fault Monitor

This block guards a speaker channel against a sustained excessive output level. Each sample period it receives a measured output-level code. It compares that code with a programmable 8-bit threshold, whose volts-per-code step is 0.02924 V. When every sample stays above the threshold for a selected number of millisecond ticks, the monitor declares a fault. A fault clears the global enable, which shuts the channel down, and raises a sticky error flag.

The host turns the channel on or off by writing the enable. After a fault the channel stays off until the host writes the enable back to 1. The error flag stays set until the host pulses a write-one-to-clear strobe.

The controller is a four-state machine:

- **OFF**: disabled by the host or by reset.
- **WATCH**: enabled, and no over-threshold run is in progress.
- **COUNT**: enabled, and every sample since the run began has been over the threshold; millisecond ticks are counted.
- **FAULT**: shut down by the monitor.

The transitions are:

- **enable-on**: OFF or FAULT to WATCH, on a host write of 1.
- **run-start**: WATCH to COUNT, on an over-threshold sample.
- **run-break**: COUNT to WATCH, on a sample at or below the threshold.
- **trip**: COUNT to FAULT, when the count reaches the duration.
- **enable-off**: any state to OFF, on a host write of 0.

Top module: `spk_fault_mon`

## Requirements
- R1: After reset `global_en` is 0 (state OFF) and `err_status` is 0.
- R2: A host write (`host_en_wr`=1) of `host_en_val`=1 in OFF or FAULT sets `global_en` to 1 after the next clock edge. A write of 0 clears `global_en` after the next edge in any state, and it takes priority over a trip in the same cycle.
- R3: A sample (`sample_tick`=1) is over the threshold only when `sample_level` > `thresh`, both unsigned. A sample equal to the threshold counts as not over.
- R4: `dur_code` selects the trip duration in millisecond ticks: 0 gives 10, 1 gives 25, 2 gives 50, 3 gives 75.
- R5: The first over sample while enabled starts a run, and a `ms_tick` in that same cycle is not counted. The D-th `ms_tick` after that, with no sample at or below the threshold in between, trips the monitor. After that edge `global_en` is 0 and `err_status` is 1.
- R6: A sample at or below the threshold during a run ends the run and restarts the count from zero. This holds even when it arrives in the same cycle as the tick that would have tripped.
- R7: Millisecond ticks have no effect while no run is in progress or while `global_en` is 0. No trip and no error can occur then.
- R8: After a trip, `global_en` stays 0 whatever samples and ticks arrive, until the host writes 1.
- R9: `err_status` stays set until an `err_clr` pulse, which clears it after the next edge. A trip in the same cycle as `err_clr` leaves it set. `err_clr` has no effect on `global_en`.
- R10: A host write of 1 while `global_en` is already 1 leaves a run and its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_tick | input | 1 | Marks a valid output-level sample |
| sample_level | input | 8 | Measured output level code |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| thresh | input | 8 | Threshold code, 0.02924 V per step |
| dur_code | input | 2 | Trip duration selector |
| host_en_wr | input | 1 | Host enable write strobe |
| host_en_val | input | 1 | Enable value written |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| global_en | output | 1 | Global enable state |
| err_status | output | 1 | Sticky fault flag |

## Verification
The hardest situation to reach is the edge of the duration window. A release sample must land in exactly the same cycle as the tick that would trip, and an error clear must coincide with a trip. Both make a one-cycle difference.

Directed sequences count ticks from the run-start edge so that these coincidences fall on chosen cycles. A long pseudo-random phase then mixes dense over-threshold samples, sparse releases and host writes. Throughout, a behavioural model is compared against the design on every clock.

// File: rtl/spkmon_pkg.sv
package spkmon_pkg;

    typedef enum logic [1:0] {
        MON_OFF   = 2'd0,
        MON_WATCH = 2'd1,
        MON_COUNT = 2'd2,
        MON_FAULT = 2'd3
    } mon_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spkmon_level_cmp.sv
module spkmon_level_cmp #(
    parameter int LVL_W = 8
) (
    input  logic             sample_tick,
    input  logic [LVL_W-1:0] sample_level,
    input  logic [LVL_W-1:0] thresh,
    output logic             samp_over,
    output logic             samp_under
);
    logic above;

    always_comb begin
        above      = (sample_level > thresh);
        samp_over  = sample_tick & above;
        samp_under = sample_tick & ~above;
    end
endmodule

// File: rtl/spkmon_dur_sel.sv
module spkmon_dur_sel #(
    parameter int CNT_W  = 7,
    parameter int DUR_N  = 4,
    parameter int CODE_W = 2,
    parameter int DUR0   = 10,
    parameter int DUR1   = 25,
    parameter int DUR2   = 50,
    parameter int DUR3   = 75
) (
    input  logic [CODE_W-1:0] dur_code,
    output logic [CNT_W-1:0]  dur_limit
);
    logic [CNT_W-1:0] lim_tab [DUR_N];

    for (genvar g = 0; g < DUR_N; g++) begin : g_tab
        localparam int VAL = (g == 0) ? DUR0 : (g == 1) ? DUR1 : (g == 2) ? DUR2 : DUR3;
        assign lim_tab[g] = CNT_W'(VAL);
    end

    always_comb begin
        dur_limit = lim_tab[dur_code];
    end
endmodule

// File: rtl/spkmon_dwell_cnt.sv
module spkmon_dwell_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             cnt_inc,
    input  logic [CNT_W-1:0] dur_limit,
    output logic             dwell_hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   next_val;

    always_comb begin
        next_val  = {1'b0, cnt_q} + 1'b1;
        dwell_hit = cnt_inc & (next_val >= {1'b0, dur_limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else if (cnt_inc && !(&cnt_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spk_fault_mon.sv
module spk_fault_mon
    import spkmon_pkg::*;
#(
    parameter int LVL_W  = 8,
    parameter int CODE_W = 2,
    parameter int DUR0   = 10,
    parameter int DUR1   = 25,
    parameter int DUR2   = 50,
    parameter int DUR3   = 75
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic [LVL_W-1:0]  sample_level,
    input  logic              ms_tick,
    input  logic [LVL_W-1:0]  thresh,
    input  logic [CODE_W-1:0] dur_code,
    input  logic              host_en_wr,
    input  logic              host_en_val,
    input  logic              err_clr,
    output logic              global_en,
    output logic              err_status
);
    localparam int DUR_N   = 1 << CODE_W;
    localparam int DUR_MAX = int'(max2(max2(DUR0, DUR1), max2(DUR2, DUR3)));
    localparam int CNT_W   = $clog2(DUR_MAX + 1);

    mon_state_e       st_q, st_nx;
    logic             samp_over, samp_under;
    logic             wr_on, wr_off;
    logic             cnt_clr, cnt_inc, dwell_hit, trip;
    logic [CNT_W-1:0] dur_limit;
    logic             err_q;

    spkmon_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .sample_tick (sample_tick),
        .sample_level(sample_level),
        .thresh      (thresh),
        .samp_over   (samp_over),
        .samp_under  (samp_under)
    );

    spkmon_dur_sel #(
        .CNT_W(CNT_W), .DUR_N(DUR_N), .CODE_W(CODE_W),
        .DUR0(DUR0), .DUR1(DUR1), .DUR2(DUR2), .DUR3(DUR3)
    ) u_dur (
        .dur_code (dur_code),
        .dur_limit(dur_limit)
    );

    spkmon_dwell_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .dur_limit(dur_limit),
        .dwell_hit(dwell_hit)
    );

    always_comb begin
        wr_on  = host_en_wr & host_en_val;
        wr_off = host_en_wr & ~host_en_val;
        st_nx  = st_q;
        unique case (st_q)
            MON_OFF:   if (wr_on) st_nx = MON_WATCH;
            MON_WATCH: if (samp_over) st_nx = MON_COUNT;
            MON_COUNT: begin
                if (samp_under)     st_nx = MON_WATCH;
                else if (dwell_hit) st_nx = MON_FAULT;
            end
            MON_FAULT: if (wr_on) st_nx = MON_WATCH;
            default:   st_nx = MON_OFF;
        endcase
        if (wr_off) st_nx = MON_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MON_OFF;
        else        st_q <= st_nx;
    end

    always_comb begin
        global_en = (st_q == MON_WATCH) || (st_q == MON_COUNT);
        cnt_inc   = (st_q == MON_COUNT) && ms_tick;
        cnt_clr   = (st_nx != MON_COUNT);
        trip      = (st_q == MON_COUNT) && (st_nx == MON_FAULT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (trip)    err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    assign err_status = err_q;
endmodule

// File: rtl/spk_fault_mon_chk.sv
module spk_fault_mon_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic [LVL_W-1:0] sample_level,
    input logic [LVL_W-1:0] thresh,
    input logic             host_en_wr,
    input logic             host_en_val,
    input logic             err_clr,
    input logic             global_en,
    input logic             err_status
);
    // R5
    fault_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status) |-> !global_en);

    // R7
    trip_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status) |-> $past(global_en));

    // R2
    write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en_wr && !host_en_val) |=> !global_en);

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!global_en && !(host_en_wr && host_en_val)) |=> !global_en);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !err_clr) |=> err_status);

    // R6
    release_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (global_en && sample_tick && (sample_level <= thresh) && !host_en_wr) |=> global_en);
endmodule

bind spk_fault_mon spk_fault_mon_chk #(.LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .sample_level(sample_level),
    .thresh      (thresh),
    .host_en_wr  (host_en_wr),
    .host_en_val (host_en_val),
    .err_clr     (err_clr),
    .global_en   (global_en),
    .err_status  (err_status)
);

// File: tb/spk_fault_mon_bench.sv
module spk_fault_mon_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic [7:0] sample_level = '0;
    logic       ms_tick = 1'b0;
    logic [7:0] thresh = 8'd100;
    logic [1:0] dur_code = 2'd0;
    logic       host_en_wr = 1'b0;
    logic       host_en_val = 1'b0;
    logic       err_clr = 1'b0;
    logic       global_en, err_status;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    bit m_en, m_run, m_err;
    int m_cnt;

    always #10 clk = ~clk;

    spk_fault_mon u_spk_fault_mon (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .sample_level(sample_level),
        .ms_tick(ms_tick), .thresh(thresh), .dur_code(dur_code), .host_en_wr(host_en_wr),
        .host_en_val(host_en_val), .err_clr(err_clr), .global_en(global_en),
        .err_status(err_status)
    );

    function automatic int dur_of(input logic [1:0] c);
        case (c)
            2'd0: return 10;
            2'd1: return 25;
            2'd2: return 50;
            default: return 75;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit trip;
        trip = 1'b0;
        if (!rst_n) begin
            m_en = 0; m_run = 0; m_err = 0; m_cnt = 0;
        end else begin
            if (host_en_wr && !host_en_val) begin
                m_en = 0; m_run = 0; m_cnt = 0;
            end else if (!m_en) begin
                if (host_en_wr && host_en_val) m_en = 1;
                m_run = 0; m_cnt = 0;
            end else if (sample_tick && sample_level <= thresh) begin
                m_run = 0; m_cnt = 0;
            end else if (m_run) begin
                if (ms_tick) begin
                    m_cnt++;
                    if (m_cnt >= dur_of(dur_code)) begin
                        trip = 1; m_en = 0; m_run = 0; m_cnt = 0;
                    end
                end
            end else if (sample_tick && sample_level > thresh) begin
                m_run = 1; m_cnt = 0;
            end
            if (trip) m_err = 1;
            else if (err_clr) m_err = 0;
        end
    end

    always @(posedge clk) begin
        #2;
        cycles++;
        if (rst_n && !done) begin
            check(global_en == m_en, "R2/R5/R8 model global_en", global_en, m_en);
            check(err_status == m_err, "R9 model err_status", err_status, m_err);
        end
    end

    task automatic step(input bit st, input logic [7:0] lvl, input bit mt,
                        input bit we, input bit wv, input bit clr);
        @(negedge clk);
        sample_tick = st; sample_level = lvl; ms_tick = mt;
        host_en_wr = we; host_en_val = wv; err_clr = clr;
        @(posedge clk);
        #3;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'd0, 0, 0, 0, 0);
    endtask

    // enable, start a run, tick until trip; returns ticks used
    task automatic trip_len(input logic [1:0] code, output int n);
        dur_code = code;
        step(0, 0, 0, 1, 1, 0);
        step(1, thresh + 8'd5, 1, 0, 0, 0);
        n = 0;
        while (global_en && n < 200) begin
            step(1, thresh + 8'd1, 1, 0, 0, 0);
            n++;
        end
    endtask

    initial begin
        int n;
        for (int w = 0; w < 150000; w++) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        bad++; total++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #3;
        check(global_en == 0, "R1 reset global_en", global_en, 0);
        check(err_status == 0, "R1 reset err_status", err_status, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        check(global_en == 0, "R1 off after reset", global_en, 0);

        // R7: ticks while disabled
        for (int i = 0; i < 20; i++) step(1, 8'd200, 1, 0, 0, 0);
        check(err_status == 0, "R7 no trip while off", err_status, 0);

        // R2 enable
        step(0, 0, 0, 1, 1, 0);
        check(global_en == 1, "R2 write 1", global_en, 1);
        // R7 ticks in WATCH do not count
        for (int i = 0; i < 30; i++) step(0, 0, 1, 0, 0, 0);
        step(1, 8'd101, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) step(1, 8'd150, 1, 0, 0, 0);
        check(global_en == 1, "R5/R7 nine ticks no trip", global_en, 1);
        step(0, 0, 1, 0, 0, 0);
        check(global_en == 0, "R5 tenth tick trips", global_en, 0);
        check(err_status == 1, "R5 error set", err_status, 1);

        // R8 hold in fault
        for (int i = 0; i < 15; i++) step(1, 8'd10, 1, 0, 0, 0);
        check(global_en == 0, "R8 stays off", global_en, 0);
        // R9 clear
        step(0, 0, 0, 0, 0, 1);
        check(err_status == 0, "R9 clear", err_status, 0);
        check(global_en == 0, "R9 clear leaves enable", global_en, 0);

        // R3 equal sample is not over; R6 release on final tick
        step(0, 0, 0, 1, 1, 0);
        step(1, 8'd100, 1, 0, 0, 0);
        for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 0, 0);
        check(global_en == 1, "R3 equal level no run", global_en, 1);
        step(1, 8'd120, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0, 0);
        step(1, 8'd100, 1, 0, 0, 0);
        check(global_en == 1, "R6 release on tripping tick", global_en, 1);
        step(1, 8'd120, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0, 0);
        check(global_en == 1, "R6 count restarted", global_en, 1);

        // R10 write 1 mid-run has no effect; trip with clear in same cycle (R9)
        step(0, 0, 0, 1, 1, 0);
        step(0, 0, 1, 0, 0, 1);
        check(global_en == 0 && err_status == 1, "R10/R9 trip wins over clear", err_status, 1);

        // R2 write 0 beats trip
        step(0, 0, 0, 1, 1, 0);
        step(1, 8'd130, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 0, 1);
        step(0, 0, 1, 1, 0, 0);
        check(global_en == 0 && err_status == 0, "R2 write 0 beats trip", err_status, 0);

        // R4 durations
        for (int c = 0; c < 4; c++) begin
            trip_len(2'(c), n);
            check(n == dur_of(2'(c)), "R4 duration", n, dur_of(2'(c)));
            step(0, 0, 0, 0, 0, 1);
        end

        // mixed random phase against model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (i % 700 == 0) thresh = 8'($urandom_range(20, 200));
            if (i % 333 == 0) dur_code = 2'($urandom_range(0, 3));
            step(($urandom_range(0, 3) != 0),
                 (r < 4) ? thresh : (r < 8) ? 8'd0 : 8'd255,
                 ($urandom_range(0, 2) == 0),
                 (r >= 97), (r != 97), ($urandom_range(0, 60) == 0));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule